// File: doc/BRIEF.md
# Disk Drive Command and Attention Register Block

This block is the command front end of a disk drive's register file. A bus slave hands it register writes and reads. It keeps the control, status, three error and attention-summary registers. A control write with the start bit set launches a function. The block checks the function code against the set of legal codes. Head-motion functions are held busy until an external positioning-done pulse arrives. Every other legal function completes at once. A single attention line tells the controller when the drive needs service.

Attention has three sources: the end of a positioning function, a detected error during a started command while the drive is on line, and a change of the on-line input. A change of the on-line input raises no attention when it follows an unload command. The controller clears attention in two ways: it writes a one to this drive's bit of the attention-summary register, or it issues a drive-clear command. A drive clear also empties all error registers.

Top module: `drv_cmd_attn`

## Requirements
- R1: After reset, the status register (select 1) reads 0x0180: drive-present bit 8 and ready bit 7 are set. The control (select 0) and error registers read 0, and `attn_out` is low.
- R2: A control write with data bit 0 (start) set and code 03, 05, 07, 15 or 17 (octal, bits 5:0) holds the function busy. Status bit 13 (positioning) is set and bit 7 (ready) is clear. The control register reads back code bits 5:1 with bit 0 still set.
- R3: A started code 01, 13, 21, 23, 31, 61, 63, 71 or 73 completes at once. Start reads 0, ready stays 1, and no error bit or attention is raised.
- R4: A started code outside the legal set sets bit 0 of error register 1 (select 2). Status bit 14 (composite error) goes to 1 and start stays 0. Attention is raised only if the drive is on line.
- R5: A `pos_done` pulse while a positioning function is busy clears start and positioning, and raises attention. A `pos_done` pulse while the drive is idle has no effect.
- R6: Control writes made while a function is busy are ignored.
- R7: A started code 11 (drive clear) zeroes all three error registers and clears attention. It never raises attention.
- R8: A change of `online_in` raises attention two clocks later. Status bit 12 follows `online_in`, and status bit 11 follows `wrlock_in`, one clock later.
- R9: After an unload (code 03) has been started, the next change of `online_in` raises no attention. Later changes raise it again.
- R10: The attention-summary register (select 4) reads `attn_out` at bit DRV_ID. Writing a 1 to that bit clears attention, and writing a 0 leaves it unchanged. Status bit 15 mirrors attention.
- R11: A read or write with a select of 16 or above sets bit 1 of error register 1, and such a read returns 0.
- R12: A pulse on `ext_err` sets bit 3 of error register 1. It raises attention only when a positioning function is busy and the drive is on line.
- R13: Error registers 1, 2 and 3 (selects 2, 12 and 13) are written and read back by software. Status bit 14 is the OR of all their bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Write register select |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 5 | Read register select |
| rd_data | output | 16 | Read data, valid the clock after `rd_en` |
| online_in | input | 1 | Drive on-line status |
| wrlock_in | input | 1 | Write-protect status |
| pos_done | input | 1 | Positioning finished pulse |
| ext_err | input | 1 | Detected bus parity error pulse |
| attn_out | output | 1 | Attention request |

## Verification
A busy flag left set shows at once as a cleared ready bit in status, and every later control write is lost. A missed positioning completion leaves `attn_out` low on the clock after `pos_done`. A stale unload-pending flag shows only at the next on-line change: attention stays low there, or rises where it should not. That is checked two clocks after each change of `online_in`. Error-register corruption shows in the composite-error status bit on the very next read.

// File: rtl/drv_cmd_pkg.sv
package drv_cmd_pkg;
  localparam int REG_W = 16;
  localparam int SEL_W = 5;
  localparam int FN_W  = 6;

  localparam logic [SEL_W-1:0] SEL_CTRL = 5'd0;
  localparam logic [SEL_W-1:0] SEL_STAT = 5'd1;
  localparam logic [SEL_W-1:0] SEL_ERR1 = 5'd2;
  localparam logic [SEL_W-1:0] SEL_ATTN = 5'd4;
  localparam logic [SEL_W-1:0] SEL_ERR2 = 5'd12;
  localparam logic [SEL_W-1:0] SEL_ERR3 = 5'd13;

  // status bit positions
  localparam int ST_ATTN = 15;
  localparam int ST_CERR = 14;
  localparam int ST_PIP  = 13;
  localparam int ST_ONL  = 12;
  localparam int ST_WLK  = 11;
  localparam int ST_PRES = 8;
  localparam int ST_RDY  = 7;

  // error register 1 bit positions
  localparam int E1_BADFN  = 0;
  localparam int E1_BADREG = 1;
  localparam int E1_PAR    = 3;

  // function codes (octal)
  localparam logic [FN_W-1:0] FN_NOP     = 6'o01;
  localparam logic [FN_W-1:0] FN_UNLOAD  = 6'o03;
  localparam logic [FN_W-1:0] FN_SEEK    = 6'o05;
  localparam logic [FN_W-1:0] FN_RECAL   = 6'o07;
  localparam logic [FN_W-1:0] FN_DCLR    = 6'o11;
  localparam logic [FN_W-1:0] FN_RELEASE = 6'o13;
  localparam logic [FN_W-1:0] FN_OFFSET  = 6'o15;
  localparam logic [FN_W-1:0] FN_CENTER  = 6'o17;
  localparam logic [FN_W-1:0] FN_PRESET  = 6'o21;
  localparam logic [FN_W-1:0] FN_PACKACK = 6'o23;
  localparam logic [FN_W-1:0] FN_SEARCH  = 6'o31;
  localparam logic [FN_W-1:0] FN_WR      = 6'o61;
  localparam logic [FN_W-1:0] FN_WRHDR   = 6'o63;
  localparam logic [FN_W-1:0] FN_RD      = 6'o71;
  localparam logic [FN_W-1:0] FN_RDHDR   = 6'o73;

  typedef struct packed {
    logic legal;
    logic motion;
    logic clear;
    logic unload;
  } fn_class_t;
endpackage

// File: rtl/drv_fn_decode.sv
module drv_fn_decode
  import drv_cmd_pkg::*;
#(
  parameter int CODE_W = FN_W
) (
  input  logic [CODE_W-1:1] code_hi,
  output fn_class_t         cls
);
  logic [CODE_W-1:0] full;
  assign full = {code_hi, 1'b1};

  always_comb begin
    cls = '0;
    case (full)
      FN_UNLOAD: begin cls.legal = 1'b1; cls.motion = 1'b1; cls.unload = 1'b1; end
      FN_SEEK, FN_RECAL, FN_OFFSET, FN_CENTER: begin
        cls.legal = 1'b1; cls.motion = 1'b1;
      end
      FN_DCLR: begin cls.legal = 1'b1; cls.clear = 1'b1; end
      FN_NOP, FN_RELEASE, FN_PRESET, FN_PACKACK, FN_SEARCH,
      FN_WR, FN_WRHDR, FN_RD, FN_RDHDR: cls.legal = 1'b1;
      default: cls = '0;
    endcase
  end
endmodule

// File: rtl/drv_err_bank.sv
module drv_err_bank #(
  parameter int W     = 16,
  parameter int NREGS = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NREGS-1:0]          sw_we,
  input  logic [W-1:0]              sw_data,
  input  logic [NREGS-1:0][W-1:0]   hw_set,
  input  logic                      clr,
  output logic [NREGS-1:0][W-1:0]   err_q,
  output logic                      cerr
);
  logic [NREGS-1:0] nz;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            err_q[i] <= '0;
      else if (clr)       err_q[i] <= hw_set[i];
      else if (sw_we[i])  err_q[i] <= sw_data | hw_set[i];
      else                err_q[i] <= err_q[i] | hw_set[i];
    end
    assign nz[i] = |err_q[i];
  end

  assign cerr = |nz;

  // R7
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr && !(|hw_set) |=> (err_q == '0));
  // R13
  sw_write_chk: assert property (@(posedge clk) disable iff (rst)
    sw_we[0] && !clr && !(|hw_set[0]) |=> (err_q[0] == $past(sw_data)));
endmodule

// File: rtl/drv_attn_ctl.sv
module drv_attn_ctl (
  input  logic clk,
  input  logic rst,
  input  logic online_in,
  input  logic set_pos,
  input  logic set_err,
  input  logic unload_arm,
  input  logic clr_dclr,
  input  logic clr_sw,
  output logic online_q,
  output logic attn_q
);
  logic on_d, pend_q, chg, line_evt, any_set, any_clr;

  assign chg      = online_q ^ on_d;
  assign line_evt = chg && !pend_q;
  assign any_set  = set_pos | set_err | line_evt;
  assign any_clr  = clr_dclr | clr_sw;

  always_ff @(posedge clk) begin
    if (rst) begin
      online_q <= online_in;
      on_d     <= online_in;
      pend_q   <= 1'b0;
      attn_q   <= 1'b0;
    end else begin
      online_q <= online_in;
      on_d     <= online_q;
      if (unload_arm)  pend_q <= 1'b1;
      else if (chg)    pend_q <= 1'b0;
      if (any_set)      attn_q <= 1'b1;
      else if (any_clr) attn_q <= 1'b0;
    end
  end

  // R8
  line_change_chk: assert property (@(posedge clk) disable iff (rst)
    chg && !pend_q |=> attn_q);
  // R9
  unload_mask_chk: assert property (@(posedge clk) disable iff (rst)
    chg && pend_q && !set_pos && !set_err && !any_clr |=> attn_q == $past(attn_q));
  // R10
  attn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_sw && !set_pos && !set_err && !chg |=> !attn_q);
endmodule

// File: rtl/drv_cmd_attn.sv
module drv_cmd_attn
  import drv_cmd_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int ADR_W  = SEL_W,
  parameter int DRV_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADR_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADR_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              online_in,
  input  logic              wrlock_in,
  input  logic              pos_done,
  input  logic              ext_err,
  output logic              attn_out
);
  localparam int NERR = 3;

  logic [FN_W-1:1]             func_q;
  logic                        go_q, pip_q, wl_q;
  logic                        ctrl_take, go_req, start_mo, pos_cpl;
  logic                        ilf_set, ilr_set, par_set, err_attn, sw_aclr;
  logic                        online_q, attn_q, cerr;
  fn_class_t                   cls;
  logic [NERR-1:0]             err_we;
  logic [NERR-1:0][DATA_W-1:0] err_set, err_q;
  logic [DATA_W-1:0]           stat_v, rd_mux, rd_q;

  drv_fn_decode #(.CODE_W(FN_W)) u_dec (
    .code_hi (wr_data[FN_W-1:1]),
    .cls     (cls)
  );

  assign ctrl_take = wr_en && (wr_sel == SEL_CTRL) && !go_q;
  assign go_req    = ctrl_take && wr_data[0];
  assign start_mo  = go_req && cls.motion;
  assign pos_cpl   = go_q && pip_q && pos_done;
  assign ilf_set   = go_req && !cls.legal;
  assign ilr_set   = (wr_en && wr_sel[ADR_W-1]) || (rd_en && rd_sel[ADR_W-1]);
  assign par_set   = ext_err;
  assign err_attn  = online_q && (ilf_set || (go_q && (ilr_set || par_set)));
  assign sw_aclr   = wr_en && (wr_sel == SEL_ATTN) && wr_data[DRV_ID];

  assign err_we[0] = wr_en && (wr_sel == SEL_ERR1);
  assign err_we[1] = wr_en && (wr_sel == SEL_ERR2);
  assign err_we[2] = wr_en && (wr_sel == SEL_ERR3);

  always_comb begin
    err_set = '0;
    err_set[0][E1_BADFN]  = ilf_set;
    err_set[0][E1_BADREG] = ilr_set;
    err_set[0][E1_PAR]    = par_set;
  end

  drv_err_bank #(.W(DATA_W), .NREGS(NERR)) u_err (
    .clk     (clk),
    .rst     (rst),
    .sw_we   (err_we),
    .sw_data (wr_data),
    .hw_set  (err_set),
    .clr     (go_req && cls.clear),
    .err_q   (err_q),
    .cerr    (cerr)
  );

  drv_attn_ctl u_attn (
    .clk        (clk),
    .rst        (rst),
    .online_in  (online_in),
    .set_pos    (pos_cpl),
    .set_err    (err_attn),
    .unload_arm (go_req && cls.unload),
    .clr_dclr   (go_req && cls.clear),
    .clr_sw     (sw_aclr),
    .online_q   (online_q),
    .attn_q     (attn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q <= '0;
      go_q   <= 1'b0;
      pip_q  <= 1'b0;
      wl_q   <= 1'b0;
    end else begin
      wl_q <= wrlock_in;
      if (ctrl_take) func_q <= wr_data[FN_W-1:1];
      if (pos_cpl) begin
        go_q  <= 1'b0;
        pip_q <= 1'b0;
      end else if (start_mo) begin
        go_q  <= 1'b1;
        pip_q <= 1'b1;
      end
    end
  end

  always_comb begin
    stat_v          = '0;
    stat_v[ST_ATTN] = attn_q;
    stat_v[ST_CERR] = cerr;
    stat_v[ST_PIP]  = pip_q;
    stat_v[ST_ONL]  = online_q;
    stat_v[ST_WLK]  = wl_q;
    stat_v[ST_PRES] = 1'b1;
    stat_v[ST_RDY]  = !go_q;
  end

  always_comb begin
    rd_mux = '0;
    case (rd_sel)
      SEL_CTRL: rd_mux[FN_W-1:0] = {func_q, go_q};
      SEL_STAT: rd_mux = stat_v;
      SEL_ERR1: rd_mux = err_q[0];
      SEL_ATTN: rd_mux[DRV_ID] = attn_q;
      SEL_ERR2: rd_mux = err_q[1];
      SEL_ERR3: rd_mux = err_q[2];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data  = rd_q;
  assign attn_out = attn_q;

  // R2
  busy_pair_chk: assert property (@(posedge clk) disable iff (rst)
    start_mo |=> go_q && pip_q && !stat_v[ST_RDY]);
  // R5
  pos_end_chk: assert property (@(posedge clk) disable iff (rst)
    pos_cpl |=> !go_q && !pip_q && attn_out);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    go_q && !pos_cpl |=> $stable(func_q) && go_q);
  // R4
  bad_fn_chk: assert property (@(posedge clk) disable iff (rst)
    ilf_set |=> err_q[0][E1_BADFN] && !go_q);
  // R11
  bad_reg_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_sel[ADR_W-1] |=> rd_data == '0);
endmodule

// File: tb/drv_cmd_attn_test.sv
`timescale 1ns/1ps
module drv_cmd_attn_test;
  localparam int DRV_ID = 0;
  localparam logic [15:0] ABIT = 16'(1) << DRV_ID;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_sel = '0, rd_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic online_in = 1'b0, wrlock_in = 1'b0, pos_done = 1'b0, ext_err = 1'b0;
  logic attn_out;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  drv_cmd_attn #(.DRV_ID(DRV_ID)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .online_in(online_in), .wrlock_in(wrlock_in), .pos_done(pos_done),
    .ext_err(ext_err), .attn_out(attn_out)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] sel, output logic [15:0] d);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_pos();
    pos_done = 1'b1; @(negedge clk); pos_done = 1'b0;
  endtask

  task automatic pulse_err();
    ext_err = 1'b1; @(negedge clk); ext_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(5'd1, v); chk("R1 status", v, 16'h0180);
    rd(5'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(5'd2, v); chk("R1 err1", v, 16'h0000);
    chk("R1 attn", {15'd0, attn_out}, 16'h0);
  endtask

  task automatic t_immediate();
    logic [15:0] v;
    logic [5:0] codes [9] = '{6'o01, 6'o13, 6'o21, 6'o23, 6'o31, 6'o61, 6'o63, 6'o71, 6'o73};
    foreach (codes[i]) begin
      wr(5'd0, {10'd0, codes[i]});
      rd(5'd1, v); chk("R3 status after immediate code", v, 16'h0180);
    end
    rd(5'd0, v); chk("R3 ctrl start cleared", v, 16'h003A);
  endtask

  task automatic t_position();
    logic [15:0] v;
    wr(5'd0, 16'h0005);
    rd(5'd1, v); chk("R2 status busy", v, 16'h2100);
    rd(5'd0, v); chk("R2 ctrl readback", v, 16'h0005);
    wr(5'd0, 16'h0001);
    rd(5'd0, v); chk("R6 write while busy ignored", v, 16'h0005);
    chk("R2 no attn yet", {15'd0, attn_out}, 16'h0);
    pulse_pos();
    chk("R5 attn on completion", {15'd0, attn_out}, 16'h1);
    rd(5'd1, v); chk("R5 status after completion", v, 16'h8180);
    wr(5'd4, ABIT);
    chk("R10 attn cleared by summary write", {15'd0, attn_out}, 16'h0);
    pulse_pos();
    chk("R5 idle pos_done ignored", {15'd0, attn_out}, 16'h0);
    rd(5'd1, v); chk("R5 status idle", v, 16'h0180);
  endtask

  task automatic t_illegal_offline();
    logic [15:0] v;
    wr(5'd0, 16'h003F);
    rd(5'd2, v); chk("R4 bad function bit", v, 16'h0001);
    rd(5'd1, v); chk("R4 composite error offline", v, 16'h4180);
    rd(5'd0, v); chk("R4 start stays clear", v, 16'h003E);
    chk("R4 no attn offline", {15'd0, attn_out}, 16'h0);
    wr(5'd0, 16'h0009);
    rd(5'd2, v); chk("R7 err1 cleared", v, 16'h0000);
    rd(5'd1, v); chk("R7 status after clear", v, 16'h0180);
  endtask

  task automatic t_online();
    logic [15:0] v;
    online_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 attn on line change", {15'd0, attn_out}, 16'h1);
    rd(5'd1, v); chk("R8 status online", v, 16'h9180);
    wr(5'd4, 16'h0000);
    chk("R10 zero write keeps attn", {15'd0, attn_out}, 16'h1);
    rd(5'd4, v); chk("R10 summary bit", v, ABIT);
    wr(5'd4, ABIT);
    chk("R10 attn cleared", {15'd0, attn_out}, 16'h0);
    wrlock_in = 1'b1;
    @(negedge clk);
    rd(5'd1, v); chk("R8 write lock bit", v, 16'h1980);
    wrlock_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_illegal_online();
    logic [15:0] v;
    wr(5'd0, 16'h003F);
    chk("R4 attn when online", {15'd0, attn_out}, 16'h1);
    rd(5'd2, v); chk("R4 bad function online", v, 16'h0001);
    wr(5'd0, 16'h0009);
    chk("R7 drive clear drops attn", {15'd0, attn_out}, 16'h0);
    rd(5'd2, v); chk("R7 err1 zero", v, 16'h0000);
  endtask

  task automatic t_ext_err();
    logic [15:0] v;
    pulse_err();
    rd(5'd2, v); chk("R12 parity bit idle", v, 16'h0008);
    chk("R12 no attn when idle", {15'd0, attn_out}, 16'h0);
    wr(5'd0, 16'h0009);
    wr(5'd0, 16'h0005);
    pulse_err();
    chk("R12 attn when busy online", {15'd0, attn_out}, 16'h1);
    rd(5'd2, v); chk("R12 parity bit busy", v, 16'h0008);
    pulse_pos();
    wr(5'd0, 16'h0009);
    chk("R7 attn clear", {15'd0, attn_out}, 16'h0);
    rd(5'd1, v); chk("R7 status online clean", v, 16'h1180);
  endtask

  task automatic t_bad_reg();
    logic [15:0] v;
    rd(5'd20, v); chk("R11 read data zero", v, 16'h0000);
    rd(5'd2, v); chk("R11 bad register bit", v, 16'h0002);
    chk("R11 no attn idle", {15'd0, attn_out}, 16'h0);
    wr(5'd0, 16'h0009);
  endtask

  task automatic t_err_regs();
    logic [15:0] v;
    wr(5'd12, 16'h0400);
    rd(5'd12, v); chk("R13 err2 readback", v, 16'h0400);
    rd(5'd1, v); chk("R13 composite from err2", v, 16'h5180);
    wr(5'd13, 16'h8001);
    rd(5'd13, v); chk("R13 err3 readback", v, 16'h8001);
    wr(5'd2, 16'h0000);
    rd(5'd1, v); chk("R13 composite held by others", v, 16'h5180);
    wr(5'd0, 16'h0009);
    rd(5'd12, v); chk("R7 err2 cleared", v, 16'h0000);
    rd(5'd13, v); chk("R7 err3 cleared", v, 16'h0000);
  endtask

  task automatic t_unload();
    logic [15:0] v;
    wr(5'd0, 16'h0003);
    rd(5'd1, v); chk("R2 unload busy", v, 16'h3100);
    pulse_pos();
    chk("R5 unload completion attn", {15'd0, attn_out}, 16'h1);
    wr(5'd4, ABIT);
    online_in = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R9 no attn after unload", {15'd0, attn_out}, 16'h0);
    rd(5'd1, v); chk("R9 status offline", v, 16'h0180);
    online_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 later change raises attn", {15'd0, attn_out}, 16'h1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_immediate();
    t_position();
    t_illegal_offline();
    t_online();
    t_illegal_online();
    t_ext_err();
    t_bad_reg();
    t_err_regs();
    t_unload();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule